// File: doc/BRIEF.md
# Synchronizable Machine-Cycle Timing Generator

This block divides the input clock into a repeating machine cycle of fifteen clocks, made of five numbered time states with three phases each. The phase number moves on every rising clock edge. A one-clock pulse marks each entry into state 1, phase 1. A saturating tally counts the machine cycles completed since the last sync release, and a ready flag tells surrounding logic when to release a core reset.

A sync-mode enable and a sync strobe let an external agent force the divider chain into a known position on a known clock edge. Several generators, or a tester and the block it drives, can then run in lock-step. The strobe counts only once the enable has been high for a setup window. It must then stay high for a minimum hold before the chain is cleared, so short glitches leave the running cycle alone. When the strobe falls, the outputs stay idle for a fixed delay. The cycle then restarts at state 1, phase 1.

Top module: `mcg_timing_gen`

## Requirements
- R1: While `rst_n` is low, and until the first rising edge after it rises, the outputs are state 1, phase 1, `cyc_start_o`=1, count 0 and `ready_o`=0.
- R2: Outside sync, each rising edge moves the phase 1→2→3→1. When the phase wraps from 3 to 1, the state moves 1→2→…→5→1, so one machine cycle lasts 15 clocks.
- R3: `cyc_start_o` is 1 exactly on the clock cycles where the outputs show state 1, phase 1, and 0 on all others.
- R4: A strobe sample counts as qualified only if `sync_en_i` is high at that edge and was high at the 4 edges before it. An unqualified strobe has no effect.
- R5: A run of fewer than 4 consecutive qualified strobe samples has no effect. State, phase, pulse and count keep their free-running sequence.
- R6: On the 4th consecutive qualified high sample, the outputs go idle: state 0, phase 0, `cyc_start_o`=0 and count 0. They stay idle while the strobe stays qualified high.
- R7: After the strobe falls, the outputs stay idle at the first and second edges that sample it low. The third such edge shows state 1, phase 1 with `cyc_start_o`=1.
- R8: A qualified high sample during that release delay returns the block to idle and restarts the delay from the next low sample.
- R9: The count rises by one at each state 5, phase 3 → state 1, phase 1 step and saturates at 5. `ready_o` is 1 exactly while the count is 5, which first happens 75 clocks after the post-sync entry into state 1, phase 1.
- R10: Dropping `sync_en_i` once the strobe has fallen does not change when the release completes.
- R11: After reset with no sync, the count also saturates at 5 and `ready_o` rises after five full cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en_i | input | 1 | Sync-mode enable; the strobe is honoured only while it is high |
| sync_strobe_i | input | 1 | Sync strobe; a long enough high clears the divider chain |
| tstate_o | output | 3 | Current time state, 1..5, or 0 while idle |
| phase_o | output | 2 | Current phase, 1..3, or 0 while idle |
| cyc_start_o | output | 1 | One-clock pulse at state 1, phase 1 |
| cyc_count_o | output | 3 | Machine cycles completed since sync release, saturating at 5 |
| ready_o | output | 1 | High once five cycles have completed |

## Verification
The bench aims at the hold threshold. A strobe three qualified samples long must leave the sequence untouched, and a fourth must idle it. A design that counted one edge early or late would either drop the running phase on a glitch or ignore a valid sync. It also raises the strobe before the enable setup window has passed, which catches a generator that honours the strobe too soon. It pulses the strobe inside the release delay and withdraws the enable during that delay. This exposes a controller that launches at the wrong edge or gets stuck idle. Finally it checks the ready flag on the 74th and 75th clocks after release, where an off-by-one in the wrap detection or the count saturation would show.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    // Operating mode of the sync controller
    typedef enum logic [1:0] {
        SY_RUN   = 2'd0,   // free running, strobe not yet effective
        SY_ARMED = 2'd1,   // chain cleared, strobe still high
        SY_WAIT  = 2'd2    // strobe released, counting the start delay
    } sync_mode_e;

endpackage

// File: rtl/mcg_sync_ctrl.sv
module mcg_sync_ctrl
    import mcg_pkg::*;
#(
    parameter int SETUP       = 4,
    parameter int MIN_HOLD    = 4,
    parameter int START_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en_i,
    input  logic sync_strobe_i,
    output logic idle_o,
    output logic launch_o
);

    localparam int AGE_W  = $clog2(SETUP + 1);
    localparam int HOLD_W = $clog2(MIN_HOLD + 1);
    localparam int DLY_W  = $clog2(START_DELAY + 1);

    typedef struct packed {
        sync_mode_e         mode;
        logic [AGE_W-1:0]   age;
        logic [HOLD_W-1:0]  hold;
        logic [DLY_W-1:0]   dwell;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  qual;

    always_comb begin
        r_d  = r_q;
        qual = sync_en_i && (r_q.age == AGE_W'(SETUP)) && sync_strobe_i;

        // enable age, saturating at the setup window
        if (!sync_en_i) begin
            r_d.age = '0;
        end else if (r_q.age != AGE_W'(SETUP)) begin
            r_d.age = r_q.age + 1'b1;
        end

        unique case (r_q.mode)
            SY_RUN: begin
                if (qual) begin
                    if (r_q.hold == HOLD_W'(MIN_HOLD - 1)) begin
                        r_d.mode = SY_ARMED;
                        r_d.hold = '0;
                    end else begin
                        r_d.hold = r_q.hold + 1'b1;
                    end
                end else begin
                    r_d.hold = '0;
                end
            end
            SY_ARMED: begin
                if (!qual) begin
                    r_d.mode  = SY_WAIT;
                    r_d.dwell = DLY_W'(1);
                end
            end
            SY_WAIT: begin
                if (qual) begin
                    r_d.mode  = SY_ARMED;
                    r_d.dwell = '0;
                end else if (r_q.dwell == DLY_W'(START_DELAY)) begin
                    r_d.mode  = SY_RUN;
                    r_d.dwell = '0;
                end else begin
                    r_d.dwell = r_q.dwell + 1'b1;
                end
            end
            default: begin
                r_d.mode  = SY_RUN;
                r_d.hold  = '0;
                r_d.dwell = '0;
            end
        endcase

        idle_o   = (r_d.mode != SY_RUN);
        launch_o = (r_q.mode == SY_WAIT) && (r_d.mode == SY_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{mode: SY_RUN, age: '0, hold: '0, dwell: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/mcg_phase_seq.sv
module mcg_phase_seq #(
    parameter int STATES = 5,
    parameter int PHASES = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              idle_i,
    input  logic                              launch_i,
    output logic [$clog2(STATES + 1)-1:0]     tstate_o,
    output logic [$clog2(PHASES + 1)-1:0]     phase_o,
    output logic                              start_o,
    output logic                              wrap_o
);

    localparam int ST_W = $clog2(STATES + 1);
    localparam int PH_W = $clog2(PHASES + 1);

    typedef struct packed {
        logic [ST_W-1:0] tstate;
        logic [PH_W-1:0] phase;
        logic            start;
    } seq_t;

    seq_t s_d, s_q;
    logic last_phase;
    logic last_state;

    always_comb begin
        s_d        = s_q;
        last_phase = (s_q.phase == PH_W'(PHASES));
        last_state = (s_q.tstate == ST_W'(STATES));
        wrap_o     = 1'b0;

        if (idle_i) begin
            s_d.tstate = '0;
            s_d.phase  = '0;
            s_d.start  = 1'b0;
        end else if (launch_i || s_q.tstate == '0) begin
            s_d.tstate = ST_W'(1);
            s_d.phase  = PH_W'(1);
            s_d.start  = 1'b1;
        end else if (last_phase) begin
            s_d.phase  = PH_W'(1);
            s_d.tstate = last_state ? ST_W'(1) : s_q.tstate + 1'b1;
            s_d.start  = last_state;
            wrap_o     = last_state;
        end else begin
            s_d.phase  = s_q.phase + 1'b1;
            s_d.start  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{tstate: ST_W'(1), phase: PH_W'(1), start: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign tstate_o = s_q.tstate;
    assign phase_o  = s_q.phase;
    assign start_o  = s_q.start;

endmodule

// File: rtl/mcg_cycle_tally.sv
module mcg_cycle_tally #(
    parameter int LIMIT = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear_i,
    input  logic                           bump_i,
    output logic [$clog2(LIMIT + 1)-1:0]   count_o,
    output logic                           ready_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ready;
    } tally_t;

    tally_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear_i) begin
            t_d.count = '0;
        end else if (bump_i && t_q.count != CNT_W'(LIMIT)) begin
            t_d.count = t_q.count + 1'b1;
        end
        t_d.ready = (t_d.count == CNT_W'(LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{count: '0, ready: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign count_o = t_q.count;
    assign ready_o = t_q.ready;

endmodule

// File: rtl/mcg_timing_gen.sv
module mcg_timing_gen #(
    parameter int STATES      = 5,
    parameter int PHASES      = 3,
    parameter int SETUP       = 4,
    parameter int MIN_HOLD    = 4,
    parameter int START_DELAY = 2,
    parameter int READY_CYC   = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               sync_en_i,
    input  logic                               sync_strobe_i,
    output logic [$clog2(STATES + 1)-1:0]      tstate_o,
    output logic [$clog2(PHASES + 1)-1:0]      phase_o,
    output logic                               cyc_start_o,
    output logic [$clog2(READY_CYC + 1)-1:0]   cyc_count_o,
    output logic                               ready_o
);

    logic idle;
    logic launch;
    logic wrap;

    mcg_sync_ctrl #(
        .SETUP       (SETUP),
        .MIN_HOLD    (MIN_HOLD),
        .START_DELAY (START_DELAY)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_en_i     (sync_en_i),
        .sync_strobe_i (sync_strobe_i),
        .idle_o        (idle),
        .launch_o      (launch)
    );

    mcg_phase_seq #(
        .STATES (STATES),
        .PHASES (PHASES)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_i   (idle),
        .launch_i (launch),
        .tstate_o (tstate_o),
        .phase_o  (phase_o),
        .start_o  (cyc_start_o),
        .wrap_o   (wrap)
    );

    mcg_cycle_tally #(
        .LIMIT (READY_CYC)
    ) tally_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (idle),
        .bump_i  (wrap),
        .count_o (cyc_count_o),
        .ready_o (ready_o)
    );

endmodule

// File: rtl/mcg_timing_chk.sv
module mcg_timing_chk #(
    parameter int STATES    = 5,
    parameter int PHASES    = 3,
    parameter int READY_CYC = 5
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [$clog2(STATES + 1)-1:0]      tstate_o,
    input logic [$clog2(PHASES + 1)-1:0]      phase_o,
    input logic                               cyc_start_o,
    input logic [$clog2(READY_CYC + 1)-1:0]   cyc_count_o,
    input logic                               ready_o
);

    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o <= STATES) && (phase_o <= PHASES));

    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 0 && phase_o != PHASES) |=>
        (phase_o == $past(phase_o) + 1'b1 || phase_o == 0));

    a_r3_start_place: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |-> (tstate_o == 1 && phase_o == 1));

    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |=> !cyc_start_o);

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o == 0) |-> (phase_o == 0 && !cyc_start_o && cyc_count_o == 0));

    a_r7_launch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tstate_o != 0) |-> cyc_start_o);

    a_r9_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_count_o <= READY_CYC);

    a_r9_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o == (cyc_count_o == READY_CYC));

    a_r9_count_mono: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o != 0 && $past(tstate_o) != 0) |-> (cyc_count_o >= $past(cyc_count_o)));

endmodule

bind mcg_timing_gen mcg_timing_chk #(
    .STATES    (STATES),
    .PHASES    (PHASES),
    .READY_CYC (READY_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tstate_o    (tstate_o),
    .phase_o     (phase_o),
    .cyc_start_o (cyc_start_o),
    .cyc_count_o (cyc_count_o),
    .ready_o     (ready_o)
);

// File: tb/mcg_timing_gen_tb.sv
`timescale 1ns/1ps
module mcg_timing_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_en = 1'b0;
    logic       sync_strobe = 1'b0;
    logic [2:0] tstate;
    logic [1:0] phase;
    logic       cyc_start;
    logic [2:0] cyc_count;
    logic       ready;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mcg_timing_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_en_i     (sync_en),
        .sync_strobe_i (sync_strobe),
        .tstate_o      (tstate),
        .phase_o       (phase),
        .cyc_start_o   (cyc_start),
        .cyc_count_o   (cyc_count),
        .ready_o       (ready)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: timeline of the machine cycle in plain integers
    int m_age, m_hold, m_mode, m_dw, m_st, m_ph, m_start, m_cnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_age = 0; m_hold = 0; m_mode = 0; m_dw = 0;
            m_st = 1; m_ph = 1; m_start = 1; m_cnt = 0;
        end else begin
            bit q, go, wrapped;
            q  = sync_en && (m_age >= 4) && sync_strobe;
            go = 1'b0;
            m_age = sync_en ? ((m_age < 4) ? m_age + 1 : 4) : 0;
            if (m_mode == 0) begin
                if (q) begin
                    m_hold++;
                    if (m_hold >= 4) begin m_mode = 1; m_hold = 0; end
                end else m_hold = 0;
            end else if (m_mode == 1) begin
                if (!q) begin m_mode = 2; m_dw = 1; end
            end else begin
                if (q) m_mode = 1;
                else if (m_dw >= 2) begin m_mode = 0; go = 1'b1; end
                else m_dw++;
            end
            if (m_mode != 0) begin
                m_st = 0; m_ph = 0; m_start = 0; m_cnt = 0;
            end else if (go) begin
                m_st = 1; m_ph = 1; m_start = 1;
            end else begin
                wrapped = (m_st == 5 && m_ph == 3);
                m_ph++;
                if (m_ph > 3) begin
                    m_ph = 1;
                    m_st++;
                    if (m_st > 5) m_st = 1;
                end
                m_start = wrapped;
                if (wrapped && m_cnt < 5) m_cnt++;
            end
        end
    end

    // per-clock comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_val("R2 state", int'(tstate), m_st);
            check_val("R2 phase", int'(phase), m_ph);
            check_val("R3 start pulse", int'(cyc_start), m_start);
            check_val("R9 count", int'(cyc_count), m_cnt);
            check_val("R9 ready", int'(ready), (m_cnt == 5) ? 1 : 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks_not_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick();
            check_val(tag, (tstate != 0) ? 1 : 0, 1);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        check_val("R1 reset state", int'(tstate), 1);
        check_val("R1 reset phase", int'(phase), 1);
        check_val("R1 reset start", int'(cyc_start), 1);
        check_val("R1 reset count", int'(cyc_count), 0);
        check_val("R1 reset ready", int'(ready), 0);
        rst_n = 1'b1;
        tick();
        check_val("R2 first step phase", int'(phase), 2);

        // R11: free running from reset, ready after five cycles
        for (int i = 0; i < 90; i++) tick();
        check_val("R11 count saturated", int'(cyc_count), 5);
        check_val("R11 ready after free run", int'(ready), 1);

        // R4: strobe with enable low is ignored
        sync_strobe = 1'b1;
        ticks_not_idle(8, "R4 strobe without enable");
        sync_strobe = 1'b0;
        tick();

        // R4: strobe raised together with enable, inside setup window
        sync_en = 1'b1;
        sync_strobe = 1'b1;
        ticks_not_idle(6, "R4 strobe inside setup window");
        sync_strobe = 1'b0;
        sync_en = 1'b0;
        tick();

        // R5: three qualified samples leave the sequence alone
        sync_en = 1'b1;
        for (int i = 0; i < 6; i++) tick();
        sync_strobe = 1'b1;
        ticks_not_idle(3, "R5 short strobe");
        sync_strobe = 1'b0;
        ticks_not_idle(4, "R5 after short strobe");
        check_val("R5 count kept", int'(cyc_count), 5);

        // R6: fourth qualified sample idles the chain
        sync_strobe = 1'b1;
        ticks_not_idle(3, "R6 before threshold");
        tick();
        check_val("R6 idle state", int'(tstate), 0);
        check_val("R6 idle phase", int'(phase), 0);
        check_val("R6 idle count", int'(cyc_count), 0);
        for (int i = 0; i < 5; i++) begin
            tick();
            check_val("R6 held idle", int'(tstate), 0);
        end

        // R7: release timing
        sync_strobe = 1'b0;
        tick();
        check_val("R7 idle after 1st low", int'(tstate), 0);
        tick();
        check_val("R7 idle after 2nd low", int'(tstate), 0);
        tick();
        check_val("R7 launch state", int'(tstate), 1);
        check_val("R7 launch phase", int'(phase), 1);
        check_val("R7 launch start", int'(cyc_start), 1);
        tick();
        check_val("R3 pulse one clock", int'(cyc_start), 0);

        // R8: strobe pulse inside the release delay restarts it
        sync_strobe = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        sync_strobe = 1'b0;
        tick();
        sync_strobe = 1'b1;
        tick();
        check_val("R8 re-idle", int'(tstate), 0);
        sync_strobe = 1'b0;
        tick();
        check_val("R8 delay restart 1", int'(tstate), 0);
        tick();
        check_val("R8 delay restart 2", int'(tstate), 0);
        tick();
        check_val("R8 launch after restart", int'(tstate), 1);
        check_val("R8 launch start", int'(cyc_start), 1);

        // R10: enable dropped during the release delay
        sync_strobe = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        sync_strobe = 1'b0;
        tick();
        sync_en = 1'b0;
        tick();
        check_val("R10 still idle", int'(tstate), 0);
        tick();
        check_val("R10 launch state", int'(tstate), 1);
        check_val("R10 launch phase", int'(phase), 1);

        // R9: ready exactly 75 clocks after launch
        for (int i = 0; i < 74; i++) tick();
        check_val("R9 not ready at 74", int'(ready), 0);
        check_val("R9 count at 74", int'(cyc_count), 4);
        tick();
        check_val("R9 ready at 75", int'(ready), 1);
        check_val("R9 count at 75", int'(cyc_count), 5);
        for (int i = 0; i < 20; i++) tick();
        check_val("R9 count saturates", int'(cyc_count), 5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule